// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the eight-bit status word of an I2C bus interface up to date. The serial bit engine reports events as single-cycle pulses: a sampled bit, an ACK clock edge, a finished byte, an address match, lost arbitration, and START or STOP seen on the bus. Software touches the block in two ways: a write to the data register, and a write to the status word itself. The block applies the interface's set and clear rules to each flag. It raises an interrupt when a byte finishes, and it asks the bit engine to hold SCL low until software has serviced that byte.

Master mode is tracked by a three-state machine. `MD_SLAVE` is the idle state, with master mode off. `MD_MASTER` means this device drives the bus as master. `MD_DROP` means arbitration was lost and master mode is still held until the current byte ends.

The state transitions are as follows:
- `MD_SLAVE` goes to `MD_MASTER` on a status write that sets bit 7 and is not a blocked START.
- `MD_MASTER` goes to `MD_SLAVE` on a status write that clears bit 7.
- `MD_MASTER` goes to `MD_DROP` on arbitration loss.
- `MD_MASTER` goes directly to `MD_SLAVE` when arbitration loss and byte completion arrive in the same cycle.
- `MD_DROP` goes to `MD_SLAVE` on byte completion.

The status layout is:

| Bit | Flag | Meaning |
|-----|------|---------|
| 7 | master | Master mode |
| 6 | direction | 1 = transmit |
| 5 | busy | Bus busy |
| 4 | ready | Active-low pending flag: 0 = byte waiting for service |
| 3 | lost | Arbitration lost |
| 2 | drop-wait | Set in `MD_DROP` |
| 1 | addressed | Address received |
| 0 | last bit | Last bit received |

Top module: `i2cs_status_ctrl`

## Requirements
- R1: After reset the status word is 8'h10: only bit 4 (ready) is 1. `irq` and `scl_hold` are 0.
- R2: On `bit_edge` or `ack_edge`, bit 0 takes `sda_smp`. An ACK therefore reads 0 and a missing ACK reads 1. Otherwise a data-register write clears bit 0.
- R3: `addr_rx` sets bit 1. A data-register write clears bit 1, except in a cycle that also has `addr_rx`.
- R4: Arbitration loss while bit 7 is 1 has three effects at once: bit 3 sets, bit 6 clears, and bit 2 sets while bit 7 stays 1. The next `byte_done` then clears bits 7 and 2. If arbitration loss and `byte_done` arrive in the same cycle, bit 7 clears at once. A data-register write clears bit 3.
- R5: While enabled, `byte_done` or `addr_rx` drives bit 4 to 0. `irq` is a one-cycle pulse in exactly the cycle after bit 4 falls from 1 to 0. `scl_hold` is 1 exactly while bit 4 is 0.
- R6: A data-register write returns bit 4 to 1, unless `byte_done` or `addr_rx` arrives in the same cycle. While `en` is 0, bit 4 is held at 1.
- R7: Bit 5 has the following rules:
  - START detection sets it, and STOP detection clears it; START takes priority over STOP.
  - It is held at 0 while `en` is 0.
  - A status write loads it only when the written bits 7 and 6 are both 1 and the write is not a blocked START.
- R8: A status write with bits 7:5 = 3'b111 is a START request. If bit 5 is already 1, the request is blocked: bit 6 clears, bit 7 keeps its value, and bit 5 stays 1.
- R9: Bit 6 clears on arbitration loss while master, on STOP, on a blocked START, on START while not master, and on `ack_edge` with `sda_smp` = 1 while not master. Any of these clears overrides a status write in the same cycle. Otherwise a status write loads bit 6.
- R10: A status write ignores bits 3:0 of `st_wdata`. It loads bit 4 with the written value. It loads bit 7 through the state machine, and the write of bit 7 is ignored in `MD_DROP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable |
| bit_edge | input | 1 | Last data bit of a byte sampled |
| ack_edge | input | 1 | ACK clock edge sampled |
| sda_smp | input | 1 | Sampled SDA value for `bit_edge`/`ack_edge` |
| byte_done | input | 1 | Falling edge of the last clock of a byte |
| addr_rx | input | 1 | Slave or general-call address received |
| arb_loss | input | 1 | Arbitration lost on SDA |
| start_det | input | 1 | START condition detected |
| stop_det | input | 1 | STOP condition detected |
| dat_wr | input | 1 | Software write to the data register |
| st_wr | input | 1 | Software write to the status word |
| st_wdata | input | 8 | Status write data |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request pulse |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench checks the following corner cases:
- **Arbitration loss and byte end together.** A design that always passes through `MD_DROP` would keep bit 7 set one byte too long.
- **Blocked START against a free START.** Confusing the two would either let the written busy bit through or keep the transmit direction.
- **Same-cycle hardware/software collisions,** such as STOP against a direction write, or `addr_rx` against a data write. Letting software win would leave stale direction or ready bits and lose interrupts.
- **Interface disable.** Disabling must force ready high and busy low regardless of pending START pulses.
- **Low nibble of status writes.** A status write that sets the low nibble must leave the read-only bits untouched.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

    localparam int unsigned STAT_W = 8;

    // Bit positions of the status word
    localparam int unsigned B_LAST = 0;
    localparam int unsigned B_ADDR = 1;
    localparam int unsigned B_WAIT = 2;
    localparam int unsigned B_LOST = 3;
    localparam int unsigned B_RDY  = 4;
    localparam int unsigned B_BUSY = 5;
    localparam int unsigned B_DIR  = 6;
    localparam int unsigned B_MSTR = 7;

    localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << B_RDY;

    typedef enum logic [1:0] {
        MD_SLAVE  = 2'd0,
        MD_MASTER = 2'd1,
        MD_DROP   = 2'd2
    } mode_e;

endpackage

// File: rtl/i2cs_mode_fsm.sv
`timescale 1ns/1ps
module i2cs_mode_fsm
    import i2cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arb_loss,
    input  logic  byte_done,
    input  logic  sw_load,
    input  logic  sw_master,
    output mode_e mode_q,
    output logic  master,
    output logic  drop_wait
);

    mode_e mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_SLAVE;
        else        mode_q <= mode_d;
    end

    // Next-state logic: bus events take precedence over software
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MD_SLAVE: begin
                if (sw_load && sw_master) mode_d = MD_MASTER;
            end
            MD_MASTER: begin
                if (arb_loss)                   mode_d = byte_done ? MD_SLAVE : MD_DROP;
                else if (sw_load && !sw_master) mode_d = MD_SLAVE;
            end
            MD_DROP: begin
                if (byte_done) mode_d = MD_SLAVE;
            end
            default: mode_d = MD_SLAVE;
        endcase
    end

    // Output decode
    always_comb begin
        master    = (mode_q != MD_SLAVE);
        drop_wait = (mode_q == MD_DROP);
    end

    a_r4_enter_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_MASTER && arb_loss && !byte_done) |=> (mode_q == MD_DROP));

    a_r4_leave_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_DROP && byte_done) |=> (mode_q == MD_SLAVE));

    a_r10_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_DROP && !byte_done) |=> (mode_q == MD_DROP));

endmodule

// File: rtl/i2cs_flag_regs.sv
`timescale 1ns/1ps
module i2cs_flag_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic master,
    input  logic bit_edge,
    input  logic ack_edge,
    input  logic sda_smp,
    input  logic addr_rx,
    input  logic arb_loss,
    input  logic start_det,
    input  logic stop_det,
    input  logic dat_wr,
    input  logic st_wr,
    input  logic blocked,
    input  logic sw_dir,
    input  logic busy_ld,
    input  logic sw_busy,
    output logic last_q,
    output logic addr_q,
    output logic lost_q,
    output logic busy_q,
    output logic dir_q
);

    logic last_d, addr_d, lost_d, busy_d, dir_d;
    logic lost_ev, dir_clr;

    always_comb begin
        lost_ev = arb_loss && master;
        dir_clr = lost_ev || stop_det || blocked ||
                  (start_det && !master) ||
                  (ack_edge && sda_smp && !master);

        last_d = last_q;
        if (bit_edge || ack_edge) last_d = sda_smp;
        else if (dat_wr)          last_d = 1'b0;

        addr_d = addr_q;
        if (addr_rx)     addr_d = 1'b1;
        else if (dat_wr) addr_d = 1'b0;

        lost_d = lost_q;
        if (lost_ev)     lost_d = 1'b1;
        else if (dat_wr) lost_d = 1'b0;

        dir_d = dir_q;
        if (dir_clr)    dir_d = 1'b0;
        else if (st_wr) dir_d = sw_dir;

        busy_d = busy_q;
        if (!en)           busy_d = 1'b0;
        else if (start_det) busy_d = 1'b1;
        else if (stop_det)  busy_d = 1'b0;
        else if (busy_ld)   busy_d = sw_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            addr_q <= 1'b0;
            lost_q <= 1'b0;
            busy_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            last_q <= last_d;
            addr_q <= addr_d;
            lost_q <= lost_d;
            busy_q <= busy_d;
            dir_q  <= dir_d;
        end
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_edge || ack_edge) |=> (last_q == $past(sda_smp)));

    a_r3_addr_set: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rx |=> addr_q);

    a_r9_stop_dir: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !dir_q);

    a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_q);

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_det) |=> busy_q);

endmodule

// File: rtl/i2cs_pend_ctrl.sv
`timescale 1ns/1ps
module i2cs_pend_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic byte_done,
    input  logic addr_rx,
    input  logic dat_wr,
    input  logic st_wr,
    input  logic sw_rdy,
    output logic rdy_q,
    output logic irq,
    output logic scl_hold
);

    logic rdy_d;

    always_comb begin
        rdy_d = rdy_q;
        if (!en)                       rdy_d = 1'b1;
        else if (byte_done || addr_rx) rdy_d = 1'b0;
        else if (dat_wr)               rdy_d = 1'b1;
        else if (st_wr)                rdy_d = sw_rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b1;
            irq   <= 1'b0;
        end else begin
            rdy_q <= rdy_d;
            irq   <= rdy_q && !rdy_d;
        end
    end

    always_comb scl_hold = !rdy_q;

    a_r5_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_q) |-> irq);

    a_r5_irq_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !rdy_q);

    a_r6_off_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> rdy_q);

endmodule

// File: rtl/i2cs_status_ctrl.sv
`timescale 1ns/1ps
module i2cs_status_ctrl
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_edge,
    input  logic              ack_edge,
    input  logic              sda_smp,
    input  logic              byte_done,
    input  logic              addr_rx,
    input  logic              arb_loss,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              dat_wr,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              scl_hold
);

    logic  start_try, blocked, sw_load, busy_ld;
    logic  master, drop_wait;
    logic  last_q, addr_q, lost_q, busy_q, dir_q, rdy_q;
    mode_e mode_q;
    logic  unused_low;

    assign unused_low = ^{st_wdata[B_LOST:B_LAST], mode_q};

    always_comb begin
        start_try = st_wr && st_wdata[B_MSTR] && st_wdata[B_DIR] && st_wdata[B_BUSY];
        blocked   = start_try && busy_q;
        sw_load   = st_wr && !blocked;
        busy_ld   = sw_load && st_wdata[B_MSTR] && st_wdata[B_DIR];
    end

    i2cs_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_loss  (arb_loss),
        .byte_done (byte_done),
        .sw_load   (sw_load),
        .sw_master (st_wdata[B_MSTR]),
        .mode_q    (mode_q),
        .master    (master),
        .drop_wait (drop_wait)
    );

    i2cs_flag_regs u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .master    (master),
        .bit_edge  (bit_edge),
        .ack_edge  (ack_edge),
        .sda_smp   (sda_smp),
        .addr_rx   (addr_rx),
        .arb_loss  (arb_loss),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dat_wr    (dat_wr),
        .st_wr     (st_wr),
        .blocked   (blocked),
        .sw_dir    (st_wdata[B_DIR]),
        .busy_ld   (busy_ld),
        .sw_busy   (st_wdata[B_BUSY]),
        .last_q    (last_q),
        .addr_q    (addr_q),
        .lost_q    (lost_q),
        .busy_q    (busy_q),
        .dir_q     (dir_q)
    );

    i2cs_pend_ctrl u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .byte_done (byte_done),
        .addr_rx   (addr_rx),
        .dat_wr    (dat_wr),
        .st_wr     (st_wr),
        .sw_rdy    (st_wdata[B_RDY]),
        .rdy_q     (rdy_q),
        .irq       (irq),
        .scl_hold  (scl_hold)
    );

    always_comb begin
        status         = '0;
        status[B_LAST] = last_q;
        status[B_ADDR] = addr_q;
        status[B_WAIT] = drop_wait;
        status[B_LOST] = lost_q;
        status[B_RDY]  = rdy_q;
        status[B_BUSY] = busy_q;
        status[B_DIR]  = dir_q;
        status[B_MSTR] = master;
    end

    a_r8_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && en && !stop_det) |=> (status[B_BUSY] && !status[B_DIR]));

    a_r8_blocked_keeps_master: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !arb_loss && !byte_done) |=> (status[B_MSTR] == $past(status[B_MSTR])));

endmodule

// File: tb/test_i2cs_status_ctrl.sv
`timescale 1ns/1ps
module test_i2cs_status_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       bit_edge = 0, ack_edge = 0, sda_smp = 0, byte_done = 0, addr_rx = 0;
    logic       arb_loss = 0, start_det = 0, stop_det = 0, dat_wr = 0, st_wr = 0;
    logic [7:0] st_wdata = 8'h00;
    logic [7:0] status;
    logic       irq, scl_hold;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    i2cs_status_ctrl i_i2cs_status_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_edge(bit_edge), .ack_edge(ack_edge),
        .sda_smp(sda_smp), .byte_done(byte_done), .addr_rx(addr_rx), .arb_loss(arb_loss),
        .start_det(start_det), .stop_det(stop_det), .dat_wr(dat_wr), .st_wr(st_wr),
        .st_wdata(st_wdata), .status(status), .irq(irq), .scl_hold(scl_hold)
    );

    // ---------------- behavioural reference model ----------------
    bit m_last, m_addr, m_wait, m_lost, m_rdy, m_busy, m_dir, m_mstr, m_irq;
    bit o_rdy, o_busy, o_mstr, o_wait, blk, clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_mstr, m_dir, m_busy, m_lost, m_wait, m_addr, m_last, m_irq} = '0;
            m_rdy = 1;
        end else begin
            o_rdy = m_rdy; o_busy = m_busy; o_mstr = m_mstr; o_wait = m_wait;
            blk = st_wr && (st_wdata[7:5] == 3'b111) && o_busy;
            if (bit_edge || ack_edge) m_last = sda_smp; else if (dat_wr) m_last = 0;
            if (addr_rx) m_addr = 1; else if (dat_wr) m_addr = 0;
            if (arb_loss && o_mstr) m_lost = 1; else if (dat_wr) m_lost = 0;
            if (o_wait) begin
                if (byte_done) begin m_mstr = 0; m_wait = 0; end
            end else if (o_mstr && arb_loss) begin
                if (byte_done) m_mstr = 0; else m_wait = 1;
            end else if (st_wr && !blk) m_mstr = st_wdata[7];
            clr = (arb_loss && o_mstr) || stop_det || blk || (start_det && !o_mstr)
                  || (ack_edge && sda_smp && !o_mstr);
            if (clr) m_dir = 0; else if (st_wr) m_dir = st_wdata[6];
            if (!en) m_busy = 0;
            else if (start_det) m_busy = 1;
            else if (stop_det) m_busy = 0;
            else if (st_wr && !blk && st_wdata[7] && st_wdata[6]) m_busy = st_wdata[5];
            if (!en) m_rdy = 1;
            else if (byte_done || addr_rx) m_rdy = 0;
            else if (dat_wr) m_rdy = 1;
            else if (st_wr) m_rdy = st_wdata[4];
            m_irq = o_rdy && !m_rdy;
        end
    end

    function automatic string tag_of(int b);
        case (b)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5/R6";
            5: return "R7";
            6: return "R9";
            7: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e;
            e = {m_mstr, m_dir, m_busy, m_rdy, m_lost, m_wait, m_addr, m_last};
            for (int b = 0; b < 8; b++)
                chk(status[b] === e[b], tag_of(b), $sformatf("status[%0d]", b),
                    {7'd0, status[b]}, {7'd0, e[b]});
            chk(irq === m_irq, "R5", "irq", {7'd0, irq}, {7'd0, m_irq});
            chk(scl_hold === !m_rdy, "R5", "scl_hold", {7'd0, scl_hold}, {7'd0, !m_rdy});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clr_in();
        {bit_edge, ack_edge, sda_smp, byte_done, addr_rx} = '0;
        {arb_loss, start_det, stop_det, dat_wr, st_wr} = '0;
        st_wdata = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk); #2; clr_in();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual=hang expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        clr_in();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk(status === 8'h10, "R1", "reset status", status, 8'h10);
        chk({irq, scl_hold} === 2'b00, "R1", "reset irq/hold", {6'd0, irq, scl_hold}, 8'h00);
        @(posedge clk); #2;

        // R7: free START request becomes master transmit, busy written
        st_wr = 1; st_wdata = 8'hF0; tick();
        @(negedge clk);
        chk(status[7:4] === 4'hF, "R7", "start request", {4'h0, status[7:4]}, 8'h0F);
        @(posedge clk); #2;

        // R8: repeated START while busy is blocked
        st_wr = 1; st_wdata = 8'hF0; tick();
        @(negedge clk);
        chk(status[7:5] === 3'b101, "R8", "blocked start", {5'd0, status[7:5]}, 8'h05);
        @(posedge clk); #2;

        // R4: arbitration loss in master transmit
        st_wr = 1; st_wdata = 8'hD0; tick();
        arb_loss = 1; tick();
        @(negedge clk);
        chk({status[7:6], status[3:2]} === 4'b1011, "R4", "lost -> drop wait",
            {4'h0, status[7:6], status[3:2]}, 8'h0B);
        @(posedge clk); #2;
        byte_done = 1; tick();
        @(negedge clk);
        chk(status[7] === 1'b0 && status[2] === 1'b0, "R4", "master cleared at byte end",
            status, {1'b0, status[6:3], 1'b0, status[1:0]});
        chk(irq === 1'b1 && scl_hold === 1'b1, "R5", "irq and hold after byte",
            {6'd0, irq, scl_hold}, 8'h03);
        @(posedge clk); #2;

        // R10: low nibble of a status write is ignored
        snap = status;
        st_wr = 1; st_wdata = 8'h0F ^ {4'h0, snap[3:0]}; tick();
        @(negedge clk);
        chk(status[3:0] === snap[3:0], "R10", "low nibble kept",
            {4'h0, status[3:0]}, {4'h0, snap[3:0]});
        @(posedge clk); #2;

        // R6: data write releases ready, disable forces it
        dat_wr = 1; tick();
        @(negedge clk);
        chk(status[4] === 1'b1 && status[3] === 1'b0, "R6", "data write release",
            status, {status[7:5], 2'b10, status[2:0]});
        @(posedge clk); #2;
        addr_rx = 1; tick();
        en = 0; start_det = 1; tick();
        @(negedge clk);
        chk(status[5:4] === 2'b01, "R6", "disabled ready/busy", {6'd0, status[5:4]}, 8'h01);
        @(posedge clk); #2;
        en = 1;

        // R9: STOP beats a direction write
        st_wr = 1; st_wdata = 8'h40; stop_det = 1; tick();
        @(negedge clk);
        chk(status[6] === 1'b0, "R9", "stop beats write", {7'd0, status[6]}, 8'h00);
        @(posedge clk); #2;

        // random phase checked against the model every clock
        for (int i = 0; i < 4000; i++) begin
            en        = ($urandom_range(0, 39) != 0);
            bit_edge  = ($urandom_range(0, 9) == 0);
            ack_edge  = ($urandom_range(0, 9) == 0);
            sda_smp   = $urandom_range(0, 1);
            byte_done = ($urandom_range(0, 11) == 0);
            addr_rx   = ($urandom_range(0, 29) == 0);
            arb_loss  = ($urandom_range(0, 24) == 0);
            start_det = ($urandom_range(0, 24) == 0);
            stop_det  = ($urandom_range(0, 24) == 0);
            dat_wr    = ($urandom_range(0, 11) == 0);
            st_wr     = ($urandom_range(0, 9) == 0);
            st_wdata  = $urandom_range(0, 255);
            if ($urandom_range(0, 2) == 0) st_wdata[7:5] = 3'b111;
            @(posedge clk); #2;
        end
        clr_in();
        repeat (2) @(posedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule